// File: doc/BRIEF.md
# Stack and Frame Pointer Engine

This block is a one-cycle stack engine with its own word-wide storage. It keeps two byte addresses. The stack pointer marks the newest word of a full-descending stack, which grows toward lower addresses. The frame pointer gives a fixed base for the current call frame. Both pointers step by four bytes per word. The storage covers the byte window from the limit address (inclusive) up to the top address (exclusive). Both bounds are parameters, and the memory depth is derived from them.

A caller presents a command code with a data word and a signed byte offset. Pushes and pops move the stack pointer and leave the frame pointer alone. Frame enter saves the old frame pointer on the stack and sets a new frame base. Frame leave unwinds the frame and brings the saved base back. Local loads and stores reach a word at a signed offset from the frame pointer.

Every command completes on the clock edge that samples it. Read data and the three error pulses appear from that edge on. Any command that would break the window, or that uses a misaligned offset, raises one error pulse and changes nothing.

Top module: `stackFrameUnit`

## Requirements
- R1: After a synchronous reset, the stack pointer and the frame pointer both equal TOP_ADDR. dataOut and all error flags are zero, and every storage word reads as zero.
- R2: Command code 1 (push) lowers the stack pointer by 4 and stores dataIn at the new stack pointer address. The stack pointer is always a multiple of 4.
- R3: A push issued when the stack pointer equals LIMIT_ADDR raises overflow for one cycle and leaves the stack pointer and the storage unchanged.
- R4: Command code 2 (pop) loads dataOut with the word at the current stack pointer, visible after the sampling edge. The stack pointer then rises by 4.
- R5: A pop issued when the stack pointer equals TOP_ADDR raises underflow and leaves the stack pointer and dataOut unchanged.
- R6: Command code 3 (frame enter) pushes the old frame pointer, zero-extended to a word. The frame pointer becomes the new stack pointer plus the sign-extended offset. If there is no room, it raises overflow instead and changes nothing.
- R7: Push, pop, local load and local store never change the frame pointer.
- R8: Command code 5 (local load) copies the word at frame pointer plus sign-extended offset into dataOut. Command code 6 (local store) writes dataIn there. A stored local is visible to a later load or pop of the same address.
- R9: For enter, leave, load and store, an offset with bits [1:0] not equal to zero raises misalign. In that case the stack pointer, frame pointer, storage and dataOut all stay unchanged.
- R10: Command code 4 (frame leave) forms the slot address as frame pointer minus the sign-extended offset. It sets the stack pointer to the slot plus 4 and reloads the frame pointer from the slot word's low address bits, with bits [1:0] forced to zero.
- R11: If a load, store or leave address falls below LIMIT_ADDR, overflow is raised. If it is at or above TOP_ADDR, underflow is raised. Either way, no access or pointer change takes place.
- R12: Each flag is a one-cycle pulse for the command just sampled, and at most one flag is set. Command code 0 (no-op) and code 7 leave all state unchanged and clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Command code sampled each cycle |
| dataIn | input | DATA_W | Word for push or local store |
| offset | input | OFF_W | Signed byte offset for enter, leave, load, store |
| dataOut | output | DATA_W | Registered word from the last pop or local load |
| sp | output | ADDR_W | Stack pointer byte address |
| fp | output | ADDR_W | Frame pointer byte address |
| overflow | output | 1 | Pulse: access below the limit, or stack full |
| underflow | output | 1 | Pulse: access at or above the top, or stack empty |
| misalign | output | 1 | Pulse: offset not a multiple of four |

## Verification
The properties assume that TOP_ADDR and LIMIT_ADDR are word-aligned with the limit below the top. They also assume that cmd and offset are steady around the sampling edge. Under those conditions the stack pointer stays inside the window on its own, whatever the command stream.

The stimulus changes inputs only on falling edges. It mixes directed boundary sequences with a pseudo-random command stream. The random offsets stay small enough that every sum fits the widened address arithmetic. Misaligned offsets are injected on purpose, and leave commands sometimes reload the frame pointer from arbitrary data words, so the out-of-window cases arise naturally.

// File: rtl/stackPkg.sv
package stackPkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_PUSH  = 3'd1,
    CMD_POP   = 3'd2,
    CMD_ENTER = 3'd3,
    CMD_LEAVE = 3'd4,
    CMD_LOAD  = 3'd5,
    CMD_STORE = 3'd6
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic spLoad;
    logic fpLoad;
    logic fpFromMem;
    logic memWrite;
    logic wrFp;
    logic readOut;
    logic flagOvf;
    logic flagUnf;
    logic flagMis;
  } strobe_t;

endpackage

// File: rtl/stackCtrl.sv
module stackCtrl
  import stackPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 8,
  parameter int TOP_ADDR   = 'h100,
  parameter int LIMIT_ADDR = 'h0C0,
  parameter int IDX_W      = 4
) (
  input  logic [2:0]        cmdIn,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] fp,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] spNext,
  output logic [ADDR_W-1:0] fpNext,
  output logic [IDX_W-1:0]  memIdx
);

  // two guard bits keep fp +/- offset exact
  localparam int XW = ADDR_W + 2;

  logic signed [XW-1:0] offX;
  logic signed [XW-1:0] spX;
  logic signed [XW-1:0] fpX;
  logic signed [XW-1:0] limX;
  logic signed [XW-1:0] topX;
  logic signed [XW-1:0] localAddr;
  logic signed [XW-1:0] leaveSlot;
  logic                 misOff;
  logic                 stackFull;
  logic                 stackEmpty;
  logic                 localLow;
  logic                 localHigh;
  logic                 slotLow;
  logic                 slotHigh;
  logic [ADDR_W-1:0]    memAddr;
  logic [ADDR_W-1:0]    spDown;
  logic [ADDR_W-1:0]    spUp;

  assign offX      = XW'($signed(offset));
  assign spX       = $signed({2'b00, sp});
  assign fpX       = $signed({2'b00, fp});
  assign limX      = XW'(LIMIT_ADDR);
  assign topX      = XW'(TOP_ADDR);
  assign localAddr = fpX + offX;
  assign leaveSlot = fpX - offX;

  assign misOff     = |offset[1:0];
  assign stackFull  = spX < (limX + XW'(4));
  assign stackEmpty = spX >= topX;
  assign localLow   = localAddr < limX;
  assign localHigh  = localAddr >= topX;
  assign slotLow    = leaveSlot < limX;
  assign slotHigh   = leaveSlot >= topX;

  assign spDown = sp - ADDR_W'(4);
  assign spUp   = sp + ADDR_W'(4);

  always_comb begin
    strb    = '0;
    spNext  = sp;
    fpNext  = fp;
    memAddr = sp;
    case (cmd_e'(cmdIn))
      CMD_PUSH: begin
        if (stackFull) begin
          strb.flagOvf = 1'b1;
        end else begin
          strb.spLoad   = 1'b1;
          strb.memWrite = 1'b1;
          spNext        = spDown;
          memAddr       = spDown;
        end
      end
      CMD_POP: begin
        if (stackEmpty) begin
          strb.flagUnf = 1'b1;
        end else begin
          strb.spLoad  = 1'b1;
          strb.readOut = 1'b1;
          spNext       = spUp;
          memAddr      = sp;
        end
      end
      CMD_ENTER: begin
        if (misOff) begin
          strb.flagMis = 1'b1;
        end else if (stackFull) begin
          strb.flagOvf = 1'b1;
        end else begin
          strb.spLoad   = 1'b1;
          strb.memWrite = 1'b1;
          strb.wrFp     = 1'b1;
          strb.fpLoad   = 1'b1;
          spNext        = spDown;
          memAddr       = spDown;
          fpNext        = spDown + offX[ADDR_W-1:0];
        end
      end
      CMD_LEAVE: begin
        if (misOff) begin
          strb.flagMis = 1'b1;
        end else if (slotLow) begin
          strb.flagOvf = 1'b1;
        end else if (slotHigh) begin
          strb.flagUnf = 1'b1;
        end else begin
          strb.spLoad    = 1'b1;
          strb.fpFromMem = 1'b1;
          memAddr        = leaveSlot[ADDR_W-1:0];
          spNext         = leaveSlot[ADDR_W-1:0] + ADDR_W'(4);
        end
      end
      CMD_LOAD, CMD_STORE: begin
        if (misOff) begin
          strb.flagMis = 1'b1;
        end else if (localLow) begin
          strb.flagOvf = 1'b1;
        end else if (localHigh) begin
          strb.flagUnf = 1'b1;
        end else begin
          memAddr = localAddr[ADDR_W-1:0];
          if (cmd_e'(cmdIn) == CMD_LOAD) strb.readOut  = 1'b1;
          else                           strb.memWrite = 1'b1;
        end
      end
      default: begin
      end
    endcase
  end

  // word index into the window
  assign memIdx = IDX_W'((memAddr - ADDR_W'(LIMIT_ADDR)) >> 2);

endmodule

// File: rtl/stackDatapath.sv
module stackDatapath
  import stackPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int TOP_ADDR = 'h100,
  parameter int DEPTH    = 16,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] spNext,
  input  logic [ADDR_W-1:0] fpNext,
  input  logic [IDX_W-1:0]  memIdx,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] fp,
  output logic [DATA_W-1:0] dataOut,
  output logic              overflow,
  output logic              underflow,
  output logic              misalign
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdWord;

  assign wrData = strb.wrFp ? DATA_W'(fp) : dataIn;
  assign rdWord = mem[memIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= ADDR_W'(TOP_ADDR);
      fp        <= ADDR_W'(TOP_ADDR);
      dataOut   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      misalign  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      overflow  <= strb.flagOvf;
      underflow <= strb.flagUnf;
      misalign  <= strb.flagMis;
      if (strb.spLoad) sp <= spNext;
      if (strb.fpFromMem) fp <= {rdWord[ADDR_W-1:2], 2'b00};
      else if (strb.fpLoad) fp <= fpNext;
      if (strb.memWrite) mem[memIdx] <= wrData;
      if (strb.readOut) dataOut <= rdWord;
    end
  end

endmodule

// File: rtl/stackFrameUnit.sv
module stackFrameUnit
  import stackPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 8,
  parameter int TOP_ADDR   = 'h100,
  parameter int LIMIT_ADDR = 'h0C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [OFF_W-1:0]  offset,
  output logic [DATA_W-1:0] dataOut,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] fp,
  output logic              overflow,
  output logic              underflow,
  output logic              misalign
);

  localparam int DEPTH = (TOP_ADDR - LIMIT_ADDR) / 4;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  strobe_t           strb;
  logic [ADDR_W-1:0] spNext;
  logic [ADDR_W-1:0] fpNext;
  logic [IDX_W-1:0]  memIdx;

  stackCtrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TOP_ADDR(TOP_ADDR),
    .LIMIT_ADDR(LIMIT_ADDR), .IDX_W(IDX_W)
  ) uCtrl (
    .cmdIn(cmd), .offset(offset), .sp(sp), .fp(fp),
    .strb(strb), .spNext(spNext), .fpNext(fpNext), .memIdx(memIdx)
  );

  stackDatapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR),
    .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) uPath (
    .clk(clk), .rst(rst), .strb(strb), .spNext(spNext), .fpNext(fpNext),
    .memIdx(memIdx), .dataIn(dataIn), .sp(sp), .fp(fp), .dataOut(dataOut),
    .overflow(overflow), .underflow(underflow), .misalign(misalign)
  );

endmodule

// File: rtl/stackFrameUnit_chk.sv
module stackFrameUnit_chk #(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 8,
  parameter int TOP_ADDR   = 'h100,
  parameter int LIMIT_ADDR = 'h0C0
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmd,
  input logic [OFF_W-1:0]  offset,
  input logic [ADDR_W-1:0] sp,
  input logic [ADDR_W-1:0] fp,
  input logic              overflow,
  input logic              underflow,
  input logic              misalign
);

  AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    sp[1:0] == 2'b00); // R2

  AST_SP_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (int'(sp) >= LIMIT_ADDR) && (int'(sp) <= TOP_ADDR)); // R3

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd1) |=> (overflow ? (sp == $past(sp)) : (sp == $past(sp) - ADDR_W'(4)))); // R2

  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd2) |=> (underflow ? (sp == $past(sp)) : (sp == $past(sp) + ADDR_W'(4)))); // R4

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd2 && int'(sp) == TOP_ADDR) |=> underflow); // R5

  AST_FP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd1 || cmd == 3'd2 || cmd == 3'd5 || cmd == 3'd6) |=> $stable(fp)); // R7

  AST_MISALIGN_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ((cmd >= 3'd3 && cmd <= 3'd6) && offset[1:0] != 2'b00)
      |=> (misalign && $stable(sp) && $stable(fp))); // R9

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0({overflow, underflow, misalign})); // R12

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd0) |=> (!overflow && !underflow && !misalign && $stable(sp) && $stable(fp))); // R12

endmodule

bind stackFrameUnit stackFrameUnit_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TOP_ADDR(TOP_ADDR), .LIMIT_ADDR(LIMIT_ADDR)
) uChk (
  .clk(clk), .rst(rst), .cmd(cmd), .offset(offset), .sp(sp), .fp(fp),
  .overflow(overflow), .underflow(underflow), .misalign(misalign)
);

// File: tb/stackFrameUnit_test.sv
module stackFrameUnit_test;

  localparam int TOP = 'h100;
  localparam int LIM = 'h0C0;
  localparam int WORDS = (TOP - LIM) / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [31:0] dataIn = '0;
  logic [7:0]  offset = '0;
  logic [31:0] dataOut;
  logic [15:0] sp;
  logic [15:0] fp;
  logic        overflow;
  logic        underflow;
  logic        misalign;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          mSp;
  int          mFp;
  logic [31:0] mOut;
  logic        mOvf;
  logic        mUnf;
  logic        mMis;
  logic [31:0] mMem [WORDS];

  always #2 clk = ~clk;

  stackFrameUnit uut (
    .clk(clk), .rst(rst), .cmd(cmd), .dataIn(dataIn), .offset(offset),
    .dataOut(dataOut), .sp(sp), .fp(fp), .overflow(overflow),
    .underflow(underflow), .misalign(misalign)
  );

  task automatic modelReset();
    mSp = TOP; mFp = TOP; mOut = '0;
    mOvf = 1'b0; mUnf = 1'b0; mMis = 1'b0;
    for (int i = 0; i < WORDS; i++) mMem[i] = '0;
  endtask

  task automatic modelStep(input logic [2:0] c, input logic [31:0] d, input int o);
    int a;
    mOvf = 1'b0; mUnf = 1'b0; mMis = 1'b0;
    case (c)
      3'd1: begin
        if (mSp - 4 < LIM) mOvf = 1'b1;
        else begin mSp = mSp - 4; mMem[(mSp - LIM) / 4] = d; end
      end
      3'd2: begin
        if (mSp >= TOP) mUnf = 1'b1;
        else begin mOut = mMem[(mSp - LIM) / 4]; mSp = mSp + 4; end
      end
      3'd3: begin
        if ((o & 3) != 0) mMis = 1'b1;
        else if (mSp - 4 < LIM) mOvf = 1'b1;
        else begin
          mSp = mSp - 4;
          mMem[(mSp - LIM) / 4] = 32'(mFp);
          mFp = mSp + o;
        end
      end
      3'd4: begin
        a = mFp - o;
        if ((o & 3) != 0) mMis = 1'b1;
        else if (a < LIM) mOvf = 1'b1;
        else if (a >= TOP) mUnf = 1'b1;
        else begin
          mFp = int'(mMem[(a - LIM) / 4] & 32'h0000_FFFC);
          mSp = a + 4;
        end
      end
      3'd5, 3'd6: begin
        a = mFp + o;
        if ((o & 3) != 0) mMis = 1'b1;
        else if (a < LIM) mOvf = 1'b1;
        else if (a >= TOP) mUnf = 1'b1;
        else if (c == 3'd5) mOut = mMem[(a - LIM) / 4];
        else mMem[(a - LIM) / 4] = d;
      end
      default: begin
      end
    endcase
  endtask

  task automatic compare(input string tag);
    bit bad = 0;
    checks++;
    if (dataOut !== mOut) begin
      bad = 1; $display("FAIL %s dataOut actual=%h expected=%h", tag, dataOut, mOut);
    end
    if (sp !== 16'(mSp)) begin
      bad = 1; $display("FAIL %s sp actual=%h expected=%h", tag, sp, 16'(mSp));
    end
    if (fp !== 16'(mFp)) begin
      bad = 1; $display("FAIL %s fp actual=%h expected=%h", tag, fp, 16'(mFp));
    end
    if ({overflow, underflow, misalign} !== {mOvf, mUnf, mMis}) begin
      bad = 1; $display("FAIL %s flags actual=%b expected=%b", tag,
                        {overflow, underflow, misalign}, {mOvf, mUnf, mMis});
    end
    if (bad) errors++;
  endtask

  task automatic step(input logic [2:0] c, input logic [31:0] d, input int o, input string tag);
    cmd = c; dataIn = d; offset = o[7:0];
    @(posedge clk);
    modelStep(c, d, o);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string tagOf(input logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R10";
      3'd5, 3'd6: return "R8";
      default: return "R12";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog expired actual=running expected=finished");
    errors++;
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [2:0]  rc;
    int          ro;
    int          w;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;

    step(3'd2, 0, 0, "R5 pop empty");
    step(3'd1, 32'h1111_1111, 0, "R2 push");
    step(3'd1, 32'h2222_2222, 0, "R2 push");
    step(3'd2, 0, 0, "R4 pop");
    step(3'd2, 0, 0, "R4 pop");
    for (int i = 0; i < WORDS; i++) step(3'd1, 32'hA000_0000 + i, 0, "R2 fill");
    step(3'd1, 32'hDEAD_BEEF, 0, "R3 push full");
    for (int i = 0; i < WORDS; i++) step(3'd2, 0, 0, "R4 drain");
    step(3'd2, 0, 0, "R5 pop after drain");

    step(3'd3, 0, 0, "R6 enter");
    step(3'd1, 32'h0000_AAAA, 0, "R7 push in frame");
    step(3'd6, 32'h0000_5555, -4, "R8 store local");
    step(3'd5, 0, -4, "R8 load local");
    step(3'd5, 0, 0, "R8 load saved fp");
    step(3'd2, 0, 0, "R8 pop stored local");
    step(3'd3, 0, 8, "R6 enter offset");
    step(3'd5, 0, 0, "R11 load at top");
    step(3'd4, 0, 8, "R10 leave inner");
    step(3'd4, 0, 0, "R10 leave outer");
    step(3'd4, 0, 0, "R11 leave root");
    step(3'd6, 32'h1234_5678, 2, "R9 store misaligned");
    step(3'd3, 0, 1, "R9 enter misaligned");
    step(3'd4, 0, 3, "R9 leave misaligned");
    step(3'd5, 0, -128, "R11 load below limit");
    step(3'd5, 0, 2, "R9 load misaligned");
    for (int i = 0; i < WORDS; i++) step(3'd1, 32'hB000_0000 + i, 0, "R2 refill");
    step(3'd3, 0, 0, "R6 enter full");
    step(3'd0, 0, 0, "R12 nop");
    step(3'd7, 0, 0, "R12 code7");

    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 600; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      w = int'(lfsr[3:0]);
      if (w < 6) rc = 3'd1;
      else if (w < 9) rc = 3'd2;
      else if (w == 9) rc = 3'd3;
      else if (w == 10) rc = 3'd4;
      else if (w < 13) rc = 3'd5;
      else if (w < 15) rc = 3'd6;
      else rc = 3'd0;
      ro = (int'(lfsr[10:8]) - 4) * 4 + ((lfsr[15:12] == 4'd0) ? 1 : 0);
      step(rc, lfsr ^ 32'h5A5A_0F0F, ro, tagOf(rc));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule